// File: doc/BRIEF.md
# PLL Programming Sequencer

This block reprograms the divider settings of an analog PLL on request. A caller presents a target output rate in MHz together with the reference rate that feeds the PLL. The block looks the target up in a small built-in table of supported settings. Each entry holds an input divider N, a feedback multiplier M and a post-divider shift OD. When it finds a match, the block runs a fixed sequence. It first holds the PLL in reset. It then loads the three fields and releases reset in the same write. Finally it waits for the lock flag, counting polls against a bound.

When the lock flag arrives, the new settings become the last known good ones and a done pulse is raised. When the poll bound runs out, the block puts back the last good settings with a fresh reset pulse, raises a timeout pulse and sets a sticky error flag. Requests that are malformed or have no table entry are refused at once and change nothing.

Alongside the sequencer, a combinational helper answers rate-rounding queries from the same table. A readback output gives the rate implied by the N, M and OD values currently driven to the PLL.

Top module: `pll_prog_seq`

## Requirements
- R1: `rate_rb` always equals (`ref_mhz` * M / N) >> OD, computed from the N, M and OD values currently driven, with integer division.
- R2: A request with `req_rate` = 0 or `ref_mhz` = 0 raises `err` for one cycle on the cycle after acceptance. It leaves `busy` low and does not change N, M, OD or `pll_rst`.
- R3: Programming needs an exact rate match among the table entries that come before the first zero-rate entry. Otherwise the request gets the same one-cycle `err` response with nothing changed. The table is, in index order, as (rate, M, N, OD): (312,52,1,2), (504,42,1,1), (600,50,1,1), (792,66,1,1), (1008,42,1,0), (1200,50,1,0), (0,0,0,0) as terminator, and (1500,125,2,0), which is unreachable.
- R4: After an accepted request, `pll_rst` is high for exactly one cycle while the fields keep their old values. On the next cycle the new N, M and OD appear and `pll_rst` is low. The fields never change except on the cycle after `pll_rst` was high.
- R5: Polling starts on the cycle after the fields are loaded. The first cycle on which `pll_lock` is sampled high ends the sequence, and `done` pulses on the following cycle. With the lock delay D counted from reset release, `done` appears D+2 clocks after the accepting edge.
- R6: If `pll_lock` stays low for LOCK_POLLS consecutive polls, the block pulses `pll_rst` for one cycle and then restores the last settings that locked. `tmo` pulses in the same cycle as that restore, LOCK_POLLS+2 clocks after the accepting edge.
- R7: `err_sticky` rises with the first timeout and stays high until reset. Later successful programming does not clear it.
- R8: `busy` is high from the cycle after acceptance until the cycle on which `done` or `tmo` appears. Requests presented while `busy` is high are ignored. At most one of `done`, `err` and `tmo` is high in any cycle.
- R9: `qry_result` is the rate of the first reachable table entry whose rate is at least `qry_rate`. If no entry qualifies, it is the rate of entry 0.
- R10: After reset, the PLL fields hold entry 0 (N=1, M=52, OD=2), `pll_rst`, `busy`, `done`, `err`, `tmo` and `err_sticky` are low, and entry 0 is the last good setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Programming request strobe |
| req_rate | input | 16 | Requested output rate, MHz |
| ref_mhz | input | 16 | Reference (parent) rate, MHz |
| qry_rate | input | 16 | Rate to round against the table |
| qry_result | output | 16 | Rounded table rate |
| pll_lock | input | 1 | Lock flag from the PLL |
| pll_rst | output | 1 | PLL reset control |
| pll_n | output | 5 | Input divider N driven to the PLL |
| pll_m | output | 9 | Feedback multiplier M driven to the PLL |
| pll_od | output | 2 | Post-divider shift OD driven to the PLL |
| rate_rb | output | 25 | Readback rate from current fields |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: lock reached |
| err | output | 1 | One-cycle pulse: request refused |
| tmo | output | 1 | One-cycle pulse: lock timeout, rollback applied |
| err_sticky | output | 1 | Set by any timeout, cleared by reset |

## Verification
The sequencer is driven with table hits at short and medium lock delays. These runs confirm the exact done latency and the loaded fields. A lock delay far beyond the poll bound separates a correct rollback to the last locked entry from one that keeps the failed fields or returns to the reset entry. Refused requests use a zero rate, a zero reference, an off-table rate and the rate stored past the terminator. They show that refusal leaves every field alone and that the terminator is honoured. A request injected mid-sequence tells an ignoring controller apart from one that restarts. Rounding queries below, between, exactly on and above the table rates separate first-match rounding from nearest or last-match rounding.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int RATE_W    = 16;
    localparam int N_W       = 5;
    localparam int M_W       = 9;
    localparam int OD_W      = 2;
    localparam int TBL_DEPTH = 8;
    localparam int RB_W      = RATE_W + M_W;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [M_W-1:0]    m;
        logic [N_W-1:0]    n;
        logic [OD_W-1:0]   od;
    } rate_ent_t;

    typedef struct packed {
        logic [N_W-1:0]  n;
        logic [M_W-1:0]  m;
        logic [OD_W-1:0] od;
    } pll_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RST,
        ST_POLL,
        ST_BACK
    } seq_st_t;

    // Supported settings for a 24 MHz reference; a zero rate ends the list.
    function automatic rate_ent_t tbl_entry(input int idx);
        rate_ent_t e;
        case (idx)
            0:       e = '{rate: 16'd312,  m: 9'd52,  n: 5'd1, od: 2'd2};
            1:       e = '{rate: 16'd504,  m: 9'd42,  n: 5'd1, od: 2'd1};
            2:       e = '{rate: 16'd600,  m: 9'd50,  n: 5'd1, od: 2'd1};
            3:       e = '{rate: 16'd792,  m: 9'd66,  n: 5'd1, od: 2'd1};
            4:       e = '{rate: 16'd1008, m: 9'd42,  n: 5'd1, od: 2'd0};
            5:       e = '{rate: 16'd1200, m: 9'd50,  n: 5'd1, od: 2'd0};
            7:       e = '{rate: 16'd1500, m: 9'd125, n: 5'd2, od: 2'd0};
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pll_rate_table.sv
module pll_rate_table
    import pll_seq_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH
) (
    input  logic [RATE_W-1:0] req_rate,
    input  logic [RATE_W-1:0] qry_rate,
    output logic              hit,
    output pll_cfg_t          hit_cfg,
    output logic [RATE_W-1:0] qry_result
);

    rate_ent_t        ent [DEPTH];
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] match;
    logic [DEPTH-1:0] ge;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam rate_ent_t E = tbl_entry(i);
        assign ent[i] = E;
        // An entry is reachable only if no zero-rate entry precedes it.
        if (i == 0) begin : g_first
            assign live[i] = (E.rate != '0);
        end else begin : g_rest
            assign live[i] = live[i-1] && (E.rate != '0);
        end
        assign match[i] = live[i] && (E.rate == req_rate);
        assign ge[i]    = live[i] && (E.rate >= qry_rate);
    end

    // Exact lookup: lowest matching index wins.
    always_comb begin
        hit     = 1'b0;
        hit_cfg = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_cfg = '{n: ent[i].n, m: ent[i].m, od: ent[i].od};
            end
        end
    end

    // Rounding: first qualifying entry, else entry 0.
    always_comb begin
        logic found;
        found      = 1'b0;
        qry_result = ent[0].rate;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && ge[i]) begin
                qry_result = ent[i].rate;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_seq_pkg::*;
(
    input  logic [RATE_W-1:0] ref_mhz,
    input  pll_cfg_t          cfg,
    output logic [RB_W-1:0]   rate_rb
);

    logic [RB_W-1:0] vco;
    logic [RB_W-1:0] fref;

    always_comb begin
        vco  = RB_W'(ref_mhz) * RB_W'(cfg.m);
        fref = (cfg.n != '0) ? (vco / RB_W'(cfg.n)) : '0;
        rate_rb = fref >> cfg.od;
    end

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int LOCK_POLLS = 24000000,
    parameter int CNT_W      = $clog2(LOCK_POLLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [RATE_W-1:0] req_rate,
    input  logic [RATE_W-1:0] ref_mhz,
    input  logic              hit,
    input  pll_cfg_t          hit_cfg,
    input  logic              pll_lock,
    output pll_cfg_t          cfg,
    output logic              pll_rst,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              tmo,
    output logic              err_sticky
);

    localparam rate_ent_t E0      = tbl_entry(0);
    localparam pll_cfg_t  CFG_RST = '{n: E0.n, m: E0.m, od: E0.od};
    localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(LOCK_POLLS - 1);

    typedef struct packed {
        seq_st_t          st;
        pll_cfg_t         cfg;
        pll_cfg_t         good;
        pll_cfg_t         pend;
        logic             rst;
        logic             busy;
        logic             done;
        logic             err;
        logic             tmo;
        logic             sticky;
        logic [CNT_W-1:0] cnt;
    } seq_reg_t;

    localparam seq_reg_t REG_RST = '{
        st: ST_IDLE, cfg: CFG_RST, good: CFG_RST, pend: CFG_RST,
        rst: 1'b0, busy: 1'b0, done: 1'b0, err: 1'b0, tmo: 1'b0,
        sticky: 1'b0, cnt: '0
    };

    seq_reg_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        s_d.tmo  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if ((req_rate == '0) || (ref_mhz == '0) || !hit) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.pend = hit_cfg;
                        s_d.rst  = 1'b1;
                        s_d.busy = 1'b1;
                        s_d.st   = ST_RST;
                    end
                end
            end
            ST_RST: begin
                // One write loads all fields and releases reset.
                s_d.cfg = s_q.pend;
                s_d.rst = 1'b0;
                s_d.cnt = '0;
                s_d.st  = ST_POLL;
            end
            ST_POLL: begin
                if (pll_lock) begin
                    s_d.done = 1'b1;
                    s_d.good = s_q.cfg;
                    s_d.busy = 1'b0;
                    s_d.st   = ST_IDLE;
                end else if (s_q.cnt == LAST_POLL) begin
                    s_d.rst = 1'b1;
                    s_d.st  = ST_BACK;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_BACK: begin
                s_d.cfg    = s_q.good;
                s_d.rst    = 1'b0;
                s_d.tmo    = 1'b1;
                s_d.sticky = 1'b1;
                s_d.busy   = 1'b0;
                s_d.st     = ST_IDLE;
            end
            default: s_d = REG_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= REG_RST;
        else        s_q <= s_d;
    end

    assign cfg        = s_q.cfg;
    assign pll_rst    = s_q.rst;
    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign err        = s_q.err;
    assign tmo        = s_q.tmo;
    assign err_sticky = s_q.sticky;

endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
    import pll_seq_pkg::*;
#(
    parameter int LOCK_POLLS = 24000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [RATE_W-1:0] req_rate,
    input  logic [RATE_W-1:0] ref_mhz,
    input  logic [RATE_W-1:0] qry_rate,
    output logic [RATE_W-1:0] qry_result,
    input  logic              pll_lock,
    output logic              pll_rst,
    output logic [N_W-1:0]    pll_n,
    output logic [M_W-1:0]    pll_m,
    output logic [OD_W-1:0]   pll_od,
    output logic [RB_W-1:0]   rate_rb,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              tmo,
    output logic              err_sticky
);

    localparam int CNT_W = $clog2(LOCK_POLLS + 1);

    logic     hit;
    pll_cfg_t hit_cfg;
    pll_cfg_t cfg;

    pll_rate_table #(.DEPTH(TBL_DEPTH)) u_table (
        .req_rate   (req_rate),
        .qry_rate   (qry_rate),
        .hit        (hit),
        .hit_cfg    (hit_cfg),
        .qry_result (qry_result)
    );

    pll_seq_fsm #(.LOCK_POLLS(LOCK_POLLS), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_rate   (req_rate),
        .ref_mhz    (ref_mhz),
        .hit        (hit),
        .hit_cfg    (hit_cfg),
        .pll_lock   (pll_lock),
        .cfg        (cfg),
        .pll_rst    (pll_rst),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .tmo        (tmo),
        .err_sticky (err_sticky)
    );

    pll_rate_calc u_calc (
        .ref_mhz (ref_mhz),
        .cfg     (cfg),
        .rate_rb (rate_rb)
    );

    assign pll_n  = cfg.n;
    assign pll_m  = cfg.m;
    assign pll_od = cfg.od;

endmodule

// File: rtl/pll_prog_seq_chk.sv
module pll_prog_seq_chk
    import pll_seq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            pll_rst,
    input logic            pll_lock,
    input logic [N_W-1:0]  pll_n,
    input logic [M_W-1:0]  pll_m,
    input logic [OD_W-1:0] pll_od,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic            tmo,
    input logic            err_sticky
);

    // R4: reset control lasts one cycle.
    p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_rst) |=> !pll_rst);

    // R4: fields hold while reset is driven.
    p_hold_in_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> $stable({pll_n, pll_m, pll_od}));

    // R4: fields change only right after a reset cycle.
    p_load_after_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({pll_n, pll_m, pll_od}) |-> $past(pll_rst));

    // R5: done only after lock was seen.
    p_done_on_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pll_lock));

    // R6: timeout always sets the sticky flag.
    p_tmo_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> err_sticky);

    // R7: sticky flag never falls outside reset.
    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R8: single outcome per cycle.
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err, tmo}));

    // R8: reset control only while busy.
    p_rst_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> busy);

    // R8: completion ends a busy period.
    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || tmo) |-> (!busy && $past(busy)));

    // R2: refusal never comes out of a sequence.
    p_err_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !$past(busy)));

endmodule

bind pll_prog_seq pll_prog_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_rst    (pll_rst),
    .pll_lock   (pll_lock),
    .pll_n      (pll_n),
    .pll_m      (pll_m),
    .pll_od     (pll_od),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .tmo        (tmo),
    .err_sticky (err_sticky)
);

// File: tb/pll_prog_seq_bench.sv
`timescale 1ns/1ps
module pll_prog_seq_bench;

    localparam int POLLS = 40;
    localparam int K_DONE = 0;
    localparam int K_ERR  = 1;
    localparam int K_TMO  = 2;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic [15:0] req_rate;
    logic [15:0] ref_mhz;
    logic [15:0] qry_rate;
    logic [15:0] qry_result;
    logic        pll_lock;
    logic        pll_rst;
    logic [4:0]  pll_n;
    logic [8:0]  pll_m;
    logic [1:0]  pll_od;
    logic [24:0] rate_rb;
    logic        busy;
    logic        done;
    logic        err;
    logic        tmo;
    logic        err_sticky;

    pll_prog_seq #(.LOCK_POLLS(POLLS)) u_pll_prog_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_rate   (req_rate),
        .ref_mhz    (ref_mhz),
        .qry_rate   (qry_rate),
        .qry_result (qry_result),
        .pll_lock   (pll_lock),
        .pll_rst    (pll_rst),
        .pll_n      (pll_n),
        .pll_m      (pll_m),
        .pll_od     (pll_od),
        .rate_rb    (rate_rb),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .tmo        (tmo),
        .err_sticky (err_sticky)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lock_dly = 3;
    int lk_cnt = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // PLL model: lock rises lock_dly clocks after reset is released.
    always @(posedge clk) begin
        if (pll_rst)               lk_cnt <= 0;
        else if (lk_cnt < 100000)  lk_cnt <= lk_cnt + 1;
    end
    assign pll_lock = !pll_rst && (lk_cnt >= lock_dly);

    typedef struct {
        int    kind;
        int    n;
        int    m;
        int    od;
        int    due;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic int calc_rb(input int rf, input int n, input int m, input int od);
        if (n == 0) return 0;
        return ((rf * m) / n) >> od;
    endfunction

    // Monitor: compare every outcome pulse against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && (done || err || tmo)) begin
            int got;
            got = done ? K_DONE : (err ? K_ERR : K_TMO);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", $sformatf("unexpected outcome kind %0d, expected none", got));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(got == e.kind, e.tag,
                    $sformatf("outcome kind %0d, expected %0d", got, e.kind));
                chk(cyc == e.due, e.tag,
                    $sformatf("outcome cycle %0d, expected %0d", cyc, e.due));
                chk((int'(pll_n) == e.n) && (int'(pll_m) == e.m) && (int'(pll_od) == e.od),
                    e.tag, $sformatf("fields N=%0d M=%0d OD=%0d, expected N=%0d M=%0d OD=%0d",
                                     pll_n, pll_m, pll_od, e.n, e.m, e.od));
                chk(int'(rate_rb) == calc_rb(int'(ref_mhz), e.n, e.m, e.od), "R1",
                    $sformatf("readback %0d, expected %0d", rate_rb,
                              calc_rb(int'(ref_mhz), e.n, e.m, e.od)));
            end
        end
    end

    // Driver: present one request and push its expected outcome.
    task automatic issue(input int rate, input int kind, input int lat,
                         input int ln, input int lm, input int lod,
                         input int rn, input int rm, input int rod,
                         input string tag);
        exp_t e;
        int pn, pm, pod;
        @(negedge clk);
        pn = int'(pll_n); pm = int'(pll_m); pod = int'(pll_od);
        req_valid = 1'b1;
        req_rate  = 16'(rate);
        e.kind = kind; e.n = rn; e.m = rm; e.od = rod;
        e.due = cyc + lat; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (kind == K_ERR) begin
            chk(!busy && !pll_rst, "R2",
                $sformatf("busy=%0d rst=%0d after refused request, expected 0 0", busy, pll_rst));
        end else begin
            chk(busy && pll_rst && (int'(pll_n) == pn) && (int'(pll_m) == pm) && (int'(pll_od) == pod),
                "R4", $sformatf("busy=%0d rst=%0d N=%0d M=%0d, expected 1 1 %0d %0d",
                                busy, pll_rst, pll_n, pll_m, pn, pm));
            @(negedge clk);
            chk(!pll_rst && (int'(pll_n) == ln) && (int'(pll_m) == lm) && (int'(pll_od) == lod),
                "R4", $sformatf("rst=%0d N=%0d M=%0d OD=%0d, expected 0 %0d %0d %0d",
                                pll_rst, pll_n, pll_m, pll_od, ln, lm, lod));
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 500; i++) begin
            if (exp_q.size() == 0 && !busy) break;
            @(negedge clk);
        end
        chk(exp_q.size() == 0, "R8",
            $sformatf("pending outcomes %0d, expected 0", exp_q.size()));
    endtask

    task automatic query(input int q, input int exp_r, input string tag);
        qry_rate = 16'(q);
        #1;
        chk(int'(qry_result) == exp_r, tag,
            $sformatf("round(%0d) = %0d, expected %0d", q, qry_result, exp_r));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_rate = '0; ref_mhz = 16'd24; qry_rate = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state.
        chk(pll_n == 5'd1 && pll_m == 9'd52 && pll_od == 2'd2, "R10",
            $sformatf("reset fields N=%0d M=%0d OD=%0d, expected 1 52 2", pll_n, pll_m, pll_od));
        chk(!pll_rst && !busy && !done && !err && !tmo && !err_sticky, "R10",
            $sformatf("reset flags rst=%0d busy=%0d sticky=%0d, expected 0 0 0", pll_rst, busy, err_sticky));
        chk(rate_rb == 25'd312, "R1", $sformatf("reset readback %0d, expected 312", rate_rb));

        // R9: rounding queries.
        query(600, 600, "R9");
        query(700, 792, "R9");
        query(313, 504, "R9");
        query(0, 312, "R9");
        query(1300, 312, "R9");
        query(1200, 1200, "R9");

        // R5: locked programming, two lock delays.
        lock_dly = 4;
        issue(600, K_DONE, 3 + 4, 1, 50, 1, 1, 50, 1, "R5");
        drain();
        lock_dly = 1;
        issue(1008, K_DONE, 3 + 1, 1, 42, 0, 1, 42, 0, "R5");
        drain();

        // R2: zero rate and zero reference refused.
        issue(0, K_ERR, 1, 0, 0, 0, 1, 42, 0, "R2");
        drain();
        ref_mhz = 16'd0;
        issue(600, K_ERR, 1, 0, 0, 0, 1, 42, 0, "R2");
        drain();
        ref_mhz = 16'd24;

        // R3: off-table rate and entry beyond the terminator refused.
        issue(777, K_ERR, 1, 0, 0, 0, 1, 42, 0, "R3");
        drain();
        issue(1500, K_ERR, 1, 0, 0, 0, 1, 42, 0, "R3");
        drain();

        // R8: a second request during a sequence is ignored.
        lock_dly = 10;
        issue(792, K_DONE, 3 + 10, 1, 66, 1, 1, 66, 1, "R8");
        @(negedge clk);
        req_valid = 1'b1; req_rate = 16'd504;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R8", $sformatf("busy=%0d during sequence, expected 1", busy));
        drain();
        chk(pll_n == 5'd1 && pll_m == 9'd66 && pll_od == 2'd1, "R8",
            $sformatf("fields M=%0d OD=%0d after ignored request, expected 66 1", pll_m, pll_od));

        // R6: lock never comes; rollback to the 792 setting.
        chk(!err_sticky, "R7", $sformatf("sticky=%0d before timeout, expected 0", err_sticky));
        lock_dly = 1000;
        issue(1200, K_TMO, 3 + POLLS, 1, 50, 0, 1, 66, 1, "R6");
        drain();
        chk(err_sticky, "R7", $sformatf("sticky=%0d after timeout, expected 1", err_sticky));

        // R7: later success keeps the sticky flag.
        lock_dly = 2;
        issue(312, K_DONE, 3 + 2, 1, 52, 2, 1, 52, 2, "R5");
        drain();
        chk(err_sticky, "R7", $sformatf("sticky=%0d after success, expected 1", err_sticky));
        chk(rate_rb == 25'd312, "R1", $sformatf("readback %0d, expected 312", rate_rb));

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule